// File: doc/BRIEF.md
# Multi-Channel PWM Generator with Shared Prescalers

This block drives a set of pulse-width-modulated output pins from a small pool of shared timebases. Each timebase (prescaler) counts ticks from a source it selects, either a fast tick or a slow tick. A 16-bit divider stretches each tick into one step, and an 8-bit cycle counter runs over a programmable number of steps to set the period. Every channel picks one prescaler through a 2-bit field. Its pin is active while that prescaler's cycle counter is below the channel's own duty value. A channel can also be inverted, or stopped by its gate bit.

Software programs the block through a byte-wide write port. The `fast_tick` and `slow_tick` inputs are clock-enable pulses that stand in for the two tick sources. Period, divider and duty writes to a running channel first go to shadow copies. They reach the working registers only at the end of the current period of the prescaler concerned, so a running fan or LED never sees a cut pulse or a stretched period. There is also no forced low pulse while the new values are applied.

Top module: `pwm_multi`

## Requirements
- R1: With a source tick on every clock, the output period is (D+1)×(C+1) clocks. D is the prescaler's divider value and C is its cycle value; the cycle register of prescaler p is at address 0x12+4p.
- R2: The divider is 16 bits wide. Its low byte is at 0x10+4p and its high byte at 0x11+4p. For example, D=0x0100 with C=1 gives a 514-clock period.
- R3: Bit p of the source register (address 0x01) set to 1 selects `fast_tick` for prescaler p. Set to 0, it selects `slow_tick`.
- R4: A channel is active while its prescaler's cycle counter is below the channel's duty value. The duty register of channel ch is at address 0x30+ch. Over one period, the active time is min(duty, C+1)×(D+1) ticks, so a duty above C gives a constantly active output.
- R5: A duty value of 0 on an ungated channel gives a constantly inactive output.
- R6: While a channel's gate bit is 1 (register 0x03, bit ch), its output holds the inactive level, which is the value of its polarity bit. A duty written to a gated channel takes effect at once.
- R7: Polarity bit ch (register 0x02) set to 1 inverts channel ch, so the active time over a period becomes the period minus the R4 value.
- R8: Divider, cycle and duty writes to a running channel are applied only when the prescaler concerned wraps. Every pulse and period seen is therefore either entirely the old one or entirely the new one.
- R9: While the global count enable (register 0x00, bit 0) is 0, all prescaler counters hold at zero. An ungated channel with a nonzero duty is then constantly active.
- R10: Channel ch uses the prescaler given by bits [(ch mod 4)×2+1 : (ch mod 4)×2] of the select register at 0x04+ch/4. Several channels may share one prescaler, and each keeps its own duty.
- R11: After reset, all channels are gated with polarity 0, so every output is 0. Counting is disabled, and all other registers are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| fast_tick | input | 1 | Fast source tick enable |
| slow_tick | input | 1 | Slow source tick enable |
| pwm_out | output | NUM_CH | Channel output pins |

## Verification
The bench keeps the default build: eight channels, four prescalers and 8-bit cycle and duty values. This reaches both select registers, and a prescaler shared by two channels. It sweeps duty across and beyond a short period, and sweeps small divider and cycle values, so exact pulse counts and periods can be predicted arithmetically. A 16-bit divider value exercises the high byte. A monitor records every pulse width and period while duty and period are changed mid-cycle, to catch any pulse that mixes old and new settings.

// File: rtl/pwm_multi_pkg.sv
package pwm_multi_pkg;
  // width of a channel's prescaler select field and channels per select byte
  localparam int SEL_W      = 2;
  localparam int CH_PER_SEL = 4;
  localparam int DIV_W      = 16;
  localparam int PS_STRIDE  = 4;

  localparam logic [7:0] ADR_CTRL = 8'h00;
  localparam logic [7:0] ADR_SRC  = 8'h01;
  localparam logic [7:0] ADR_POL  = 8'h02;
  localparam logic [7:0] ADR_GATE = 8'h03;
  localparam logic [7:0] ADR_SEL  = 8'h04;
  localparam logic [7:0] ADR_PS   = 8'h10;
  localparam logic [7:0] ADR_DUTY = 8'h30;

  typedef enum logic [1:0] {
    PS_DIV_LO = 2'd0,
    PS_DIV_HI = 2'd1,
    PS_CYC    = 2'd2
  } ps_field_e;
endpackage

// File: rtl/pwm_multi_rstsync.sv
module pwm_multi_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_sn = sync_q[1];
endmodule

// File: rtl/pwm_multi_regs.sv
module pwm_multi_regs
  import pwm_multi_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int NUM_PS = 4,
  parameter int CYC_W  = 8
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 wr_en,
  input  logic [7:0]                           wr_addr,
  input  logic [7:0]                           wr_data,
  output logic                                 count_en,
  output logic [NUM_PS-1:0]                    src_fast,
  output logic [NUM_CH-1:0]                    pol,
  output logic [NUM_CH-1:0]                    gate,
  output logic [NUM_CH-1:0][SEL_W-1:0]         ch_sel,
  output logic [NUM_PS-1:0][DIV_W-1:0]         div_sh,
  output logic [NUM_PS-1:0][CYC_W-1:0]         cyc_sh,
  output logic [NUM_CH-1:0][CYC_W-1:0]         duty_sh
);
  localparam int NUM_SEL = (NUM_CH + CH_PER_SEL - 1) / CH_PER_SEL;

  logic                          ctrl_q, ctrl_d;
  logic [NUM_PS-1:0]             src_q, src_d;
  logic [NUM_CH-1:0]             pol_q, pol_d;
  logic [NUM_CH-1:0]             gate_q, gate_d;
  logic [NUM_SEL-1:0][7:0]       sel_q, sel_d;
  logic [NUM_PS-1:0][DIV_W-1:0]  div_q, div_d;
  logic [NUM_PS-1:0][CYC_W-1:0]  cyc_q, cyc_d;
  logic [NUM_CH-1:0][CYC_W-1:0]  duty_q, duty_d;

  always_comb begin
    ctrl_d = ctrl_q;
    src_d  = src_q;
    pol_d  = pol_q;
    gate_d = gate_q;
    sel_d  = sel_q;
    div_d  = div_q;
    cyc_d  = cyc_q;
    duty_d = duty_q;
    if (wr_en) begin
      if (wr_addr == ADR_CTRL) ctrl_d = wr_data[0];
      if (wr_addr == ADR_SRC)  src_d  = wr_data[NUM_PS-1:0];
      if (wr_addr == ADR_POL)  pol_d  = wr_data[NUM_CH-1:0];
      if (wr_addr == ADR_GATE) gate_d = wr_data[NUM_CH-1:0];
      for (int s = 0; s < NUM_SEL; s++) begin
        if (wr_addr == 8'(ADR_SEL + s)) sel_d[s] = wr_data;
      end
      for (int p = 0; p < NUM_PS; p++) begin
        if (wr_addr == 8'(ADR_PS + p*PS_STRIDE + int'(PS_DIV_LO))) div_d[p][7:0]  = wr_data;
        if (wr_addr == 8'(ADR_PS + p*PS_STRIDE + int'(PS_DIV_HI))) div_d[p][15:8] = wr_data;
        if (wr_addr == 8'(ADR_PS + p*PS_STRIDE + int'(PS_CYC)))    cyc_d[p] = wr_data[CYC_W-1:0];
      end
      for (int c = 0; c < NUM_CH; c++) begin
        if (wr_addr == 8'(ADR_DUTY + c)) duty_d[c] = wr_data[CYC_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= 1'b0;
      src_q  <= '0;
      pol_q  <= '0;
      gate_q <= '1;
      sel_q  <= '0;
      div_q  <= '0;
      cyc_q  <= '0;
      duty_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      src_q  <= src_d;
      pol_q  <= pol_d;
      gate_q <= gate_d;
      sel_q  <= sel_d;
      div_q  <= div_d;
      cyc_q  <= cyc_d;
      duty_q <= duty_d;
    end
  end

  // unpack the shared select bytes: channel ch sits at bit (ch mod 4)*2
  for (genvar c = 0; c < NUM_CH; c++) begin : g_sel
    assign ch_sel[c] = sel_q[c / CH_PER_SEL][(c % CH_PER_SEL)*SEL_W +: SEL_W];
  end

  assign count_en = ctrl_q;
  assign src_fast = src_q;
  assign pol      = pol_q;
  assign gate     = gate_q;
  assign div_sh   = div_q;
  assign cyc_sh   = cyc_q;
  assign duty_sh  = duty_q;
endmodule

// File: rtl/pwm_multi_prescaler.sv
module pwm_multi_prescaler
  import pwm_multi_pkg::*;
#(
  parameter int CYC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             count_en,
  input  logic             fast_tick,
  input  logic             slow_tick,
  input  logic             src_fast,
  input  logic [DIV_W-1:0] div_sh,
  input  logic [CYC_W-1:0] cyc_sh,
  output logic [CYC_W-1:0] cyc_cnt,
  output logic [CYC_W-1:0] cyc_work,
  output logic             wrap
);
  logic [DIV_W-1:0] div_cnt_q, div_cnt_d;
  logic [DIV_W-1:0] div_w_q, div_w_d;
  logic [CYC_W-1:0] cyc_cnt_q, cyc_cnt_d;
  logic [CYC_W-1:0] cyc_w_q, cyc_w_d;
  logic             tick, div_end, step, wrap_c;

  always_comb begin
    tick    = src_fast ? fast_tick : slow_tick;
    div_end = (div_cnt_q == div_w_q);
    step    = count_en && tick && div_end;
    wrap_c  = step && (cyc_cnt_q == cyc_w_q);

    div_cnt_d = div_cnt_q;
    cyc_cnt_d = cyc_cnt_q;
    if (!count_en) begin
      div_cnt_d = '0;
      cyc_cnt_d = '0;
    end else if (tick) begin
      div_cnt_d = div_end ? '0 : div_cnt_q + 1'b1;
      if (step) cyc_cnt_d = wrap_c ? '0 : cyc_cnt_q + 1'b1;
    end

    // shadow values reach the working copy only at a period boundary
    div_w_d = div_w_q;
    cyc_w_d = cyc_w_q;
    if (!count_en || wrap_c) begin
      div_w_d = div_sh;
      cyc_w_d = cyc_sh;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt_q <= '0;
      div_w_q   <= '0;
      cyc_cnt_q <= '0;
      cyc_w_q   <= '0;
    end else begin
      div_cnt_q <= div_cnt_d;
      div_w_q   <= div_w_d;
      cyc_cnt_q <= cyc_cnt_d;
      cyc_w_q   <= cyc_w_d;
    end
  end

  assign cyc_cnt  = cyc_cnt_q;
  assign cyc_work = cyc_w_q;
  assign wrap     = wrap_c;
endmodule

// File: rtl/pwm_multi_channel.sv
module pwm_multi_channel #(
  parameter int CYC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             count_en,
  input  logic             gate,
  input  logic             pol,
  input  logic [CYC_W-1:0] duty_sh,
  input  logic [CYC_W-1:0] cyc_cnt,
  input  logic             wrap,
  output logic [CYC_W-1:0] duty_work,
  output logic             out
);
  logic [CYC_W-1:0] duty_q, duty_d;
  logic             out_q, out_d;
  logic             load, active;

  always_comb begin
    load   = gate || !count_en || wrap;
    duty_d = load ? duty_sh : duty_q;
    active = (cyc_cnt < duty_q);
    out_d  = gate ? pol : (active ^ pol);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty_q <= '0;
      out_q  <= 1'b0;
    end else begin
      duty_q <= duty_d;
      out_q  <= out_d;
    end
  end

  assign duty_work = duty_q;
  assign out       = out_q;
endmodule

// File: rtl/pwm_multi.sv
module pwm_multi
  import pwm_multi_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int NUM_PS = 4,
  parameter int CYC_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [7:0]        wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              fast_tick,
  input  logic              slow_tick,
  output logic [NUM_CH-1:0] pwm_out
);
  localparam logic [SEL_W:0] NPS_EXT = (SEL_W+1)'(NUM_PS);

  logic                          rst_sn;
  logic                          count_en;
  logic [NUM_PS-1:0]             src_fast;
  logic [NUM_CH-1:0]             pol, gate;
  logic [NUM_CH-1:0][SEL_W-1:0]  ch_sel;
  logic [NUM_PS-1:0][DIV_W-1:0]  div_sh;
  logic [NUM_PS-1:0][CYC_W-1:0]  cyc_sh;
  logic [NUM_CH-1:0][CYC_W-1:0]  duty_sh;
  logic [NUM_PS-1:0][CYC_W-1:0]  cyc_cnt, cyc_w;
  logic [NUM_PS-1:0]             ps_wrap;
  logic [NUM_CH-1:0][CYC_W-1:0]  duty_w;

  pwm_multi_rstsync u_rst (.clk(clk), .rst_n(rst_n), .rst_sn(rst_sn));

  pwm_multi_regs #(.NUM_CH(NUM_CH), .NUM_PS(NUM_PS), .CYC_W(CYC_W)) u_regs (
    .clk(clk), .rst_n(rst_sn), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .count_en(count_en), .src_fast(src_fast), .pol(pol), .gate(gate),
    .ch_sel(ch_sel), .div_sh(div_sh), .cyc_sh(cyc_sh), .duty_sh(duty_sh)
  );

  for (genvar p = 0; p < NUM_PS; p++) begin : g_ps
    pwm_multi_prescaler #(.CYC_W(CYC_W)) u_ps (
      .clk(clk), .rst_n(rst_sn), .count_en(count_en),
      .fast_tick(fast_tick), .slow_tick(slow_tick), .src_fast(src_fast[p]),
      .div_sh(div_sh[p]), .cyc_sh(cyc_sh[p]),
      .cyc_cnt(cyc_cnt[p]), .cyc_work(cyc_w[p]), .wrap(ps_wrap[p])
    );
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [SEL_W-1:0] idx;
    // a select value naming a missing prescaler falls back to prescaler 0
    assign idx = ({1'b0, ch_sel[c]} < NPS_EXT) ? ch_sel[c] : '0;

    pwm_multi_channel #(.CYC_W(CYC_W)) u_ch (
      .clk(clk), .rst_n(rst_sn), .count_en(count_en),
      .gate(gate[c]), .pol(pol[c]), .duty_sh(duty_sh[c]),
      .cyc_cnt(cyc_cnt[idx]), .wrap(ps_wrap[idx]),
      .duty_work(duty_w[c]), .out(pwm_out[c])
    );
  end
endmodule

// File: rtl/pwm_multi_chk.sv
module pwm_multi_chk #(
  parameter int NUM_CH = 8,
  parameter int NUM_PS = 4,
  parameter int CYC_W  = 8
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         count_en,
  input logic [NUM_CH-1:0]            gate,
  input logic [NUM_CH-1:0]            pol,
  input logic [NUM_CH-1:0]            pwm_out,
  input logic [NUM_CH-1:0][CYC_W-1:0] duty_w,
  input logic [NUM_PS-1:0][CYC_W-1:0] cyc_cnt,
  input logic [NUM_PS-1:0][CYC_W-1:0] cyc_w
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_chc
    // R6: a gated channel rests at its polarity level
    assert_gate_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      gate[c] |=> (pwm_out[c] == $past(pol[c])));
    // R5: zero duty never drives the active level
    assert_zero_duty_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!gate[c] && (duty_w[c] == '0)) |=> (pwm_out[c] == $past(pol[c])));
  end

  for (genvar p = 0; p < NUM_PS; p++) begin : g_psc
    // R1: the cycle counter never passes the working cycle value
    assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
      count_en |-> (cyc_cnt[p] <= cyc_w[p]));
    // R8: while counting, the working period changes only at a wrap
    assert_period_at_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (count_en && $past(count_en) && (cyc_w[p] != $past(cyc_w[p]))) |-> (cyc_cnt[p] == '0));
    // R9: counting disabled holds the counter at zero
    assert_idle_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !count_en |=> (cyc_cnt[p] == '0));
  end
endmodule

bind pwm_multi pwm_multi_chk #(.NUM_CH(NUM_CH), .NUM_PS(NUM_PS), .CYC_W(CYC_W)) u_chk (
  .clk(clk), .rst_n(rst_sn), .count_en(count_en), .gate(gate), .pol(pol),
  .pwm_out(pwm_out), .duty_w(duty_w), .cyc_cnt(cyc_cnt), .cyc_w(cyc_w)
);

// File: tb/pwm_multi_test.sv
`timescale 1ns/1ps
module pwm_multi_test;
  localparam int NUM_CH = 8;
  localparam real HALF = 4.0;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic [7:0]        wr_addr = '0;
  logic [7:0]        wr_data = '0;
  logic              fast_tick = 1'b1;
  logic              slow_tick = 1'b0;
  logic [NUM_CH-1:0] pwm_out;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  pwm_multi uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .fast_tick(fast_tick), .slow_tick(slow_tick), .pwm_out(pwm_out)
  );

  always #(HALF) clk = ~clk;

  // slow tick: one pulse every 4 clocks
  initial begin
    int sc = 0;
    forever begin
      @(negedge clk);
      sc = (sc + 1) % 4;
      slow_tick = (sc == 0);
    end
  end

  // pulse monitor on channel 0 for R8
  bit mon_en = 0;
  bit m_prev = 0, seen = 0;
  int per_c = 0, hi_run = 0, mon_bad = 0, mon_pulses = 0;
  int wa = 0, wb = 0, pa = 0, pb = 0;
  always @(negedge clk) begin
    if (!mon_en) begin
      seen = 0;
      m_prev = pwm_out[0];
    end else begin
      if (!m_prev && pwm_out[0]) begin
        if (seen) begin
          mon_pulses++;
          if (per_c != pa && per_c != pb) begin
            mon_bad++;
            $display("monitor: period %0d not in {%0d,%0d}", per_c, pa, pb);
          end
        end
        seen = 1;
        per_c = 1;
        hi_run = 1;
      end else begin
        per_c++;
        if (pwm_out[0]) hi_run++;
        if (m_prev && !pwm_out[0] && seen && hi_run != wa && hi_run != wb) begin
          mon_bad++;
          $display("monitor: width %0d not in {%0d,%0d}", hi_run, wa, wb);
        end
      end
      m_prev = pwm_out[0];
    end
  end

  task automatic check(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic high_count(input int ch, input int n, output int cnt);
    cnt = 0;
    repeat (n) begin
      @(negedge clk);
      if (pwm_out[ch]) cnt++;
    end
  endtask

  task automatic period_of(input int ch, output int per);
    logic prev;
    int guard = 0;
    per = -1;
    prev = pwm_out[ch];
    while (guard < 3000) begin
      @(negedge clk); guard++;
      if (!prev && pwm_out[ch]) break;
      prev = pwm_out[ch];
    end
    if (guard >= 3000) return;
    per = 0;
    prev = 1'b1;
    while (guard < 6000) begin
      @(negedge clk); guard++; per++;
      if (!prev && pwm_out[ch]) return;
      prev = pwm_out[ch];
    end
    per = -1;
  endtask

  initial begin
    #(HALF*2*200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int v;
    idle(3);
    rst_n = 1'b1;
    idle(5);
    check(int'(pwm_out), 0, "R11 reset outputs");

    // prescaler 0: divider 1, cycle 3 -> period 8; ch0 on prescaler 0
    wr(8'h01, 8'h0F);
    wr(8'h10, 8'h01); wr(8'h11, 8'h00); wr(8'h12, 8'h03);
    wr(8'h30, 8'h00);
    wr(8'h03, 8'hFE);
    wr(8'h00, 8'h01);

    // R4 / R5: duty sweep across and past the period
    for (int d = 0; d <= 5; d++) begin
      wr(8'h30, 8'(d));
      idle(40);
      high_count(0, 8, v);
      check(v, ((d < 4) ? d : 4) * 2, (d == 0) ? "R5 zero duty" : "R4 duty sweep");
    end

    // R7: inverted, duty 1 -> 8-2 active samples
    wr(8'h30, 8'h01);
    wr(8'h02, 8'h01);
    idle(40);
    high_count(0, 8, v);
    check(v, 6, "R7 inverted");

    // R6: gated with polarity 1 rests high, with polarity 0 rests low
    wr(8'h03, 8'hFF);
    idle(3);
    high_count(0, 16, v);
    check(v, 16, "R6 gated pol1");
    wr(8'h02, 8'h00);
    idle(3);
    high_count(0, 16, v);
    check(v, 0, "R6 gated pol0");
    wr(8'h03, 8'hFE);

    // R1: period sweep, duty 1
    for (int dv = 0; dv <= 2; dv += 2) begin
      for (int k = 0; k < 3; k++) begin
        int cy;
        cy = (k == 0) ? 1 : ((k == 1) ? 2 : 5);
        wr(8'h10, 8'(dv)); wr(8'h12, 8'(cy));
        idle(60);
        period_of(0, v);
        check(v, (dv + 1) * (cy + 1), "R1 period");
      end
    end

    // R2: 16-bit divider through the high byte
    wr(8'h10, 8'h00); wr(8'h11, 8'h01); wr(8'h12, 8'h01);
    idle(1200);
    period_of(0, v);
    check(v, 514, "R2 divider high byte");
    wr(8'h11, 8'h00); wr(8'h10, 8'h01); wr(8'h12, 8'h03);
    idle(1100);

    // R3: prescaler 1 on slow source, ch1 selects it (sel byte 0 bits 3:2)
    wr(8'h14, 8'h00); wr(8'h15, 8'h00); wr(8'h16, 8'h03);
    wr(8'h31, 8'h01);
    wr(8'h04, 8'h04);
    wr(8'h01, 8'h0D);
    wr(8'h03, 8'hFC);
    idle(100);
    period_of(1, v);
    check(v, 16, "R3 slow source");
    wr(8'h01, 8'h0F);
    idle(40);
    period_of(1, v);
    check(v, 4, "R3 fast source");

    // R10: ch4 and ch5 share prescaler 2 (sel byte 1), cycle 4
    wr(8'h18, 8'h00); wr(8'h19, 8'h00); wr(8'h1A, 8'h04);
    wr(8'h34, 8'h03); wr(8'h35, 8'h02);
    wr(8'h05, 8'h0A);
    wr(8'h03, 8'hCC);
    idle(40);
    high_count(4, 5, v);
    check(v, 3, "R10 shared ch4 duty");
    high_count(5, 10, v);
    check(v, 4, "R10 shared ch5 duty");
    period_of(5, v);
    check(v, 5, "R10 ch5 period");
    period_of(0, v);
    check(v, 8, "R10 ch0 unaffected");

    // R9: counting disabled -> static active level
    wr(8'h00, 8'h00);
    idle(3);
    high_count(0, 20, v);
    check(v, 20, "R9 disabled ch0");
    high_count(1, 20, v);
    check(v, 20, "R9 disabled ch1");
    wr(8'h00, 8'h01);

    // R8: live duty then period change never gives a mixed pulse
    wr(8'h30, 8'h02);
    idle(60);
    wa = 4; wb = 6; pa = 8; pb = 8;
    mon_en = 1;
    idle(27);
    wr(8'h30, 8'h03);
    idle(40);
    wa = 6; wb = 6; pa = 8; pb = 12;
    idle(5);
    wr(8'h12, 8'h05);
    idle(70);
    mon_en = 0;
    check(mon_bad, 0, "R8 glitch-free updates");
    check(int'(mon_pulses > 6), 1, "R8 pulses observed");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule